// File: doc/BRIEF.md
# Paced Parallel Sample Capture Interface

This block takes 8-bit unsigned samples from a host over a parallel byte bus. The block generates the transfer strobe itself. It divides the system clock into a pacing pulse train, nominally 1 kHz, which gives one sample per millisecond. The train stays silent until the host raises its start-capture line. The host puts a new byte on the bus when the pacing pulse rises. The block takes that byte when the same pulse falls, so the two sides never sample and update on the same edge.

Every accepted byte leaves the block with a one-cycle valid strobe and a running sample index that starts at 1. When the programmed number of samples has arrived (7000 by default), the pulse train stops for good. A done flag then stays high until the next reset. All asynchronous inputs pass through a two-flop synchronizer, and the reset is released synchronously.

Top module: `pcap_capture`

## Requirements
- R1: While reset is applied, and until the first sample is accepted, pace_out, sample_valid and done read 0, and sample_idx and sample_data read 0.
- R2: No pacing pulse is issued until start_in has been seen to change from 0 to 1 after reset. Holding start_in low keeps pace_out at 0.
- R3: Once started, pace_out is a periodic train with a period of DIV_CYCLES clocks: high for DIV_CYCLES/2 clocks (rounded down), then low for the rest. Its first rise comes on the third clock edge after the edge that first samples start_in high. The default of 100000 gives 1 kHz from a 100 MHz clock.
- R4: sample_data takes the byte that the host held on bus_in while pace_out was high. A change of bus_in made after pace_out falls does not reach that sample.
- R5: sample_valid is a single-cycle strobe. It goes high on the clock edge after the one on which pace_out fell, and never in two consecutive cycles.
- R6: sample_idx is 1 with the first valid sample and grows by exactly one with each later one. It changes only together with sample_valid.
- R7: When sample number NUM_SAMPLES is accepted, done rises in the same cycle as that strobe. Exactly NUM_SAMPLES pacing pulses have then been issued, pace_out stays low afterwards, and done stays high until reset.
- R8: A further rise of start_in during a capture or after done has no effect on the pulse train, the index or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_in | input | 1 | Start-capture line from the host, asynchronous |
| bus_in | input | 8 | Sample byte from the host, asynchronous |
| pace_out | output | 1 | Pacing pulse train to the host |
| sample_valid | output | 1 | One-cycle strobe marking an accepted sample |
| sample_data | output | 8 | Last accepted sample byte |
| sample_idx | output | 13 | Index of the last accepted sample, first is 1 |
| done | output | 1 | Capture finished, sticky until reset |

## Verification
The bench plays the host. It changes the bus on each pulse rise and replaces the byte with its complement as soon as the pulse falls. A design that latched after the fall would therefore record the complement instead of the intended byte. Extra start pulses arrive in the middle of a capture and after completion. A design that re-armed on them would lengthen the train or restart the index. A reset in the middle of a capture, with start held high through the reset, shows whether the start edge is rebuilt cleanly from the synchronizer. A block that was off by one on the final count would emit one pulse too many or too few, and would raise done on the wrong index.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;

endpackage

// File: rtl/pcap_rst_sync.sv
module pcap_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic stage_a_q;
  logic stage_b_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_a_q <= 1'b0;
      stage_b_q <= 1'b0;
    end else begin
      stage_a_q <= 1'b1;
      stage_b_q <= stage_a_q;
    end
  end

  assign rst_n_o = stage_b_q;

endmodule

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[CHAIN_W-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/pcap_pacer.sv
module pcap_pacer #(
  parameter int unsigned DIV_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pace,
  output logic fall
);

  localparam int unsigned HIGH_CYCLES = DIV_CYCLES / 2;
  localparam int unsigned CNT_W       = $clog2(DIV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(HIGH_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pace_q, pace_n;
  logic             pace_d_q;

  always_comb begin
    cnt_n  = '0;
    pace_n = 1'b0;
    if (en) begin
      cnt_n  = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      pace_n = (cnt_q < CNT_HIGH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      pace_q   <= 1'b0;
      pace_d_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      pace_q   <= pace_n;
      pace_d_q <= pace_q;
    end
  end

  assign pace = pace_q;
  assign fall = pace_d_q & ~pace_q;

endmodule

// File: rtl/pcap_capture.sv
module pcap_capture #(
  parameter int unsigned DIV_CYCLES  = 100000,
  parameter int unsigned NUM_SAMPLES = 7000,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned IDX_W       = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic              pace_out,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_data,
  output logic [IDX_W-1:0]  sample_idx,
  output logic              done
);
  import pcap_pkg::*;

  localparam int unsigned SYNC_W = DATA_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SAMPLES - 1);

  logic              rst_int_n;
  logic [SYNC_W-1:0] sync_in, sync_out;
  logic              start_s, start_d_q, start_rise;
  logic [DATA_W-1:0] bus_s;
  logic              run_en, pace_fall;

  cap_state_e        state_q, state_n;
  logic              valid_q, valid_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              done_q, done_n;

  pcap_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  assign sync_in = {start_in, bus_in};

  pcap_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (sync_in),
    .q     (sync_out)
  );

  assign start_s    = sync_out[SYNC_W-1];
  assign bus_s      = sync_out[DATA_W-1:0];
  assign start_rise = start_s & ~start_d_q;
  assign run_en     = (state_q == CAP_RUN);

  pcap_pacer #(.DIV_CYCLES(DIV_CYCLES)) u_pacer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (run_en),
    .pace  (pace_out),
    .fall  (pace_fall)
  );

  always_comb begin
    state_n = state_q;
    valid_n = 1'b0;
    data_n  = data_q;
    idx_n   = idx_q;
    done_n  = done_q;
    unique case (state_q)
      CAP_IDLE: begin
        if (start_rise) state_n = CAP_RUN;
      end
      CAP_RUN: begin
        if (pace_fall) begin
          valid_n = 1'b1;
          data_n  = bus_s;
          idx_n   = idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            state_n = CAP_DONE;
            done_n  = 1'b1;
          end
        end
      end
      default: begin
        state_n = CAP_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_d_q <= 1'b0;
      state_q   <= CAP_IDLE;
      valid_q   <= 1'b0;
      data_q    <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      start_d_q <= start_s;
      state_q   <= state_n;
      valid_q   <= valid_n;
      data_q    <= data_n;
      idx_q     <= idx_n;
      done_q    <= done_n;
    end
  end

  assign sample_valid = valid_q;
  assign sample_data  = data_q;
  assign sample_idx   = idx_q;
  assign done         = done_q;

endmodule

// File: rtl/pcap_capture_chk.sv
module pcap_capture_chk #(
  parameter int unsigned NUM_SAMPLES = 7000,
  parameter int unsigned IDX_W       = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pace_out,
  input logic             sample_valid,
  input logic [IDX_W-1:0] sample_idx,
  input logic             done
);

  localparam logic [IDX_W-1:0] NUM_V = IDX_W'(NUM_SAMPLES);

  logic [IDX_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (sample_valid) begin
      seen_q <= sample_idx;
    end
  end

  AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pace_out); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R7

  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (sample_valid && sample_idx == NUM_V)); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R5

  AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (!pace_out && !$past(pace_out) && $past(pace_out, 2))); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> (sample_idx == seen_q + 1'b1)); // R6

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample_idx)); // R6

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sample_idx <= NUM_V); // R7

endmodule

bind pcap_capture pcap_capture_chk #(
  .NUM_SAMPLES (NUM_SAMPLES),
  .IDX_W       (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pace_out     (pace_out),
  .sample_valid (sample_valid),
  .sample_idx   (sample_idx),
  .done         (done)
);

// File: tb/tb_pcap_capture.sv
`timescale 1ns/1ps
module tb_pcap_capture;

  localparam int DIV  = 10;
  localparam int HIGH = DIV / 2;
  localparam int NS   = 12;

  logic       clk;
  logic       rst_n;
  logic       start_in;
  logic [7:0] bus_in;
  logic       pace_out;
  logic       sample_valid;
  logic [7:0] sample_data;
  logic [12:0] sample_idx;
  logic       done;

  int n_vec  = 0;
  int n_fail = 0;

  pcap_capture #(.DIV_CYCLES(DIV), .NUM_SAMPLES(NS), .DATA_W(8), .IDX_W(13)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_in     (start_in),
    .bus_in       (bus_in),
    .pace_out     (pace_out),
    .sample_valid (sample_valid),
    .sample_data  (sample_data),
    .sample_idx   (sample_idx),
    .done         (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- host emulation ----------------
  int      host_k = 0;
  bit      host_prev = 0;
  logic [7:0] exp_q[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      host_prev = 0;
    end else begin
      if (pace_out && !host_prev) begin
        logic [7:0] v;
        v = (host_k == 0) ? 8'h00 : (host_k == 1) ? 8'hFF : 8'((host_k * 37 + 11) & 255);
        host_k++;
        bus_in = v;
        exp_q.push_back(v);
      end else if (!pace_out && host_prev) begin
        bus_in = ~bus_in; // R4: junk after the falling edge
      end
      host_prev = pace_out;
    end
  end

  // ---------------- cycle reference model ----------------
  int mr1, mr2, ms1, ms2, msd, md1, md2;
  int mstate, mcnt, mpq, mpd, mvalid, mdata, midx, mdone;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; ms1 = 0; ms2 = 0; msd = 0; md1 = 0; md2 = 0;
      mstate = 0; mcnt = 0; mpq = 0; mpd = 0; mvalid = 0; mdata = 0; midx = 0; mdone = 0;
    end else begin
      if (mr2 == 0) begin
        ms1 = 0; ms2 = 0; msd = 0; md1 = 0; md2 = 0;
        mstate = 0; mcnt = 0; mpq = 0; mpd = 0; mvalid = 0; mdata = 0; midx = 0; mdone = 0;
      end else begin
        int rise, fall, en, nstate, nvalid, ndata, nidx, ndone, npq, ncnt;
        rise = (ms2 == 1 && msd == 0);
        fall = (mpd == 1 && mpq == 0);
        en   = (mstate == 1);
        nstate = mstate; nvalid = 0; ndata = mdata; nidx = midx; ndone = mdone;
        if (mstate == 0 && rise) nstate = 1;
        else if (mstate == 1 && fall) begin
          nvalid = 1; ndata = md2; nidx = midx + 1;
          if (nidx == NS) begin nstate = 2; ndone = 1; end
        end
        npq  = (en && mcnt < HIGH) ? 1 : 0;
        ncnt = en ? (mcnt + 1) % DIV : 0;
        mpd = mpq; mpq = npq; mcnt = ncnt;
        mstate = nstate; mvalid = nvalid; mdata = ndata; midx = nidx; mdone = ndone;
        msd = ms2; ms2 = ms1; ms1 = int'(start_in);
        md2 = md1; md1 = int'(bus_in);
      end
      mr2 = mr1; mr1 = 1;
    end
  end

  // ---------------- per-cycle comparison and scoreboard ----------------
  int sb_idx = 0;
  int pulses = 0;
  bit pace_seen = 0;

  always @(posedge clk) begin
    #2;
    check(int'(pace_out) == mpq, "R3 pace_out", int'(pace_out), mpq);
    check(int'(sample_valid) == mvalid, "R5 sample_valid", int'(sample_valid), mvalid);
    check(int'(sample_idx) == midx, "R6 sample_idx", int'(sample_idx), midx);
    check(int'(sample_data) == mdata, "R4 sample_data", int'(sample_data), mdata);
    check(int'(done) == mdone, "R7 done", int'(done), mdone);
    if (!rst_n) begin
      exp_q.delete();
      sb_idx = 0;
      pulses = 0;
      pace_seen = 0;
    end else begin
      if (pace_out && !pace_seen) pulses++;
      pace_seen = pace_out;
      if (sample_valid) begin
        int e;
        e = (exp_q.size() > 0) ? int'(exp_q.pop_front()) : -1;
        sb_idx++;
        check(int'(sample_data) == e, "R4 host byte", int'(sample_data), e);
        check(int'(sample_idx) == sb_idx, "R6 index step", int'(sample_idx), sb_idx);
      end
    end
  end

  task automatic wait_done();
    for (int i = 0; i < NS * DIV + 200 && !done; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk); start_in = 1'b1;
    repeat (len) @(negedge clk);
    start_in = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; start_in = 1'b0; bus_in = 8'h5A;
    repeat (5) @(negedge clk);
    check(pace_out == 0 && sample_valid == 0 && done == 0, "R1 reset outputs", int'(pace_out), 0);
    check(sample_idx == 0 && sample_data == 0, "R1 reset index/data", int'(sample_idx), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(pulses == 0, "R2 no pulse before start", pulses, 0);

    pulse_start(2);
    repeat (3 * DIV) @(negedge clk);
    pulse_start(3); // R8: ignored while running
    wait_done();
    check(done == 1, "R7 done raised", int'(done), 1);
    check(pulses == NS, "R7 pulse count", pulses, NS);
    check(sb_idx == NS, "R6 final index", sb_idx, NS);
    repeat (60) @(negedge clk);
    check(pace_out == 0 && pulses == NS, "R7 train stopped", pulses, NS);
    check(done == 1, "R7 done sticky", int'(done), 1);
    pulse_start(2); // R8: ignored after done
    repeat (40) @(negedge clk);
    check(pulses == NS && int'(sample_idx) == NS, "R8 start after done", pulses, NS);

    rst_n = 1'b0;
    @(negedge clk);
    check(done == 0 && sample_idx == 0 && pace_out == 0, "R1 reset after done", int'(sample_idx), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse_start(2);
    repeat (5 * DIV) @(negedge clk);
    check(sample_idx > 0 && done == 0, "R6 mid capture", int'(sample_idx), 4);
    start_in = 1'b1;
    rst_n = 1'b0; // reset mid-capture with start held high
    @(negedge clk);
    check(sample_idx == 0 && pace_out == 0 && sample_valid == 0, "R1 reset mid capture", int'(sample_idx), 0);
    rst_n = 1'b1;
    wait_done();
    check(done == 1 && pulses == NS, "R7 second session", pulses, NS);
    start_in = 1'b0;
    repeat (20) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule